// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte is handed over with a valid/ready handshake. The block then drives a low start bit and the data bits, least significant first. An optional parity bit follows, and then a high stop period. All timing comes from an oversampling tick supplied by an external baud generator. The tick pulses for one clock cycle sixteen times per bit.

The frame shape is chosen by a small set of configuration inputs:
- word length of five to eight bits;
- stop period of one, one-and-a-half or two bit times;
- parity of four kinds: odd, even, forced high or forced low.

These settings are captured when a frame begins, so they may change freely while a frame is on the line. A separate break input pulls the line low at once, for as long as it is held. The frame sequencing keeps running underneath the break.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line output `txd` is 1 and `in_ready` is 1.
- R2: With no frame in progress, `txd` is 1 and `in_ready` is 1. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the last stop tick of that frame has been counted.
- R3: A frame starts with a start bit of 0. The data bits follow, least significant bit first. Each of these bits lasts 16 ticks of `tick16`.
- R4: `cfg_len` sets how many data bits are sent: 0 sends 5, 1 sends 6, 2 sends 7 and 3 sends 8. Data bits above the selected length are not sent.
- R5: With `cfg_stop_long` at 0, the stop period is high for 16 ticks, whatever the word length.
- R6: With `cfg_stop_long` at 1, the stop period is high for 24 ticks when `cfg_len` is 0. For any other length it is high for 32 ticks.
- R7: With `cfg_par_en` at 0, no parity bit is sent, and the stop period follows the last data bit directly.
- R8: With `cfg_par_en` at 1 and `cfg_par_stick` at 0, a 16-tick parity bit follows the last data bit. With `cfg_par_sel` at 0 (odd), it makes the count of ones over the data and parity bits odd. With `cfg_par_sel` at 1 (even), it makes that count even.
- R9: With `cfg_par_en` at 1 and `cfg_par_stick` at 1, the parity bit is fixed: 1 when `cfg_par_sel` is 0, and 0 when `cfg_par_sel` is 1.
- R10: While `cfg_break` is 1, `txd` is 0 in the same cycle. A frame in progress keeps counting ticks under the break, and the line shows that frame's current bit again once the break is released.
- R11: The configuration inputs are sampled on the accepting edge. Changing them during a frame has no effect on that frame.
- R12: With a frame in progress and `tick16` low, the frame does not advance: `txd` and `in_ready` hold their values (apart from the effect of a change on `cfg_break`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse, 16 per bit time |
| cfg_len | input | 2 | Word length select (5 + value bits) |
| cfg_stop_long | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_sel | input | 1 | Parity polarity (odd/even, or forced level) |
| cfg_par_stick | input | 1 | Forced parity select |
| cfg_break | input | 1 | Hold the line low |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can accept a byte |
| txd | output | 1 | Serial line output |

## Verification
The assertions check the handshake and line rules that hold on every cycle:
- the idle line is high;
- `in_ready` drops after an accept;
- the start bit is low right after an accept;
- break forces the line low;
- outputs freeze when no tick arrives during a frame.

Bit ordering, word lengths, the three stop lengths, the four parity modes and the capture of the configuration at frame start can only be shown by the bench's scenarios. There, a tick-by-tick reference queue is compared with `txd` and `in_ready` on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // number of data bits for a word length code
  function automatic logic [3:0] word_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len,
  input  logic              sel,
  input  logic              stick,
  output logic              par_bit
);
  import uart_tx_pkg::*;

  logic [3:0] nbits;
  logic       ones_odd;

  always_comb begin
    nbits    = word_bits(len);
    ones_odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) ones_odd = ones_odd ^ data[i];
    end
    if (stick) par_bit = ~sel;
    else if (sel) par_bit = ones_odd;   // even: total count even
    else par_bit = ~ones_odd;           // odd: total count odd
  end

endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             phase_end
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    phase_end = busy && tick && (cnt_q == limit - CNT_W'(1));
    cnt_en    = !busy || tick;
    if (!busy || phase_end) cnt_d = '0;
    else cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_end,
  input  logic              par_bit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop_long,
  input  logic              cfg_par_en,
  input  logic              cfg_par_sel,
  input  logic              cfg_par_stick,
  output logic              in_ready,
  output logic              busy,
  output logic              line,
  output logic [CNT_W-1:0]  limit,
  output logic [DATA_W-1:0] frame_data,
  output logic [1:0]        frame_len,
  output logic              frame_par_sel,
  output logic              frame_par_stick
);
  import uart_tx_pkg::*;

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LIM_BIT  = CNT_W'(OSR);
  localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(OSR + OSR / 2);
  localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * OSR);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        len_q;
  logic              stopl_q, pen_q, psel_q, pstk_q;
  logic              accept, last_bit;

  always_comb begin
    accept   = in_valid && (state_q == ST_IDLE);
    last_bit = ({1'b0, idx_q} == IDX_W'(word_bits(len_q) - 4'd1));
    state_d  = state_q;
    idx_d    = idx_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_START;
      ST_START: if (phase_end) begin
        state_d = ST_DATA;
        idx_d   = '0;
      end
      ST_DATA:  if (phase_end) begin
        if (last_bit) state_d = pen_q ? ST_PAR : ST_STOP;
        else idx_d = idx_q + IDX_W'(1);
      end
      ST_PAR:   if (phase_end) state_d = ST_STOP;
      ST_STOP:  if (phase_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // frame settings captured on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      len_q   <= '0;
      stopl_q <= 1'b0;
      pen_q   <= 1'b0;
      psel_q  <= 1'b0;
      pstk_q  <= 1'b0;
    end else if (accept) begin
      data_q  <= in_data;
      len_q   <= cfg_len;
      stopl_q <= cfg_stop_long;
      pen_q   <= cfg_par_en;
      psel_q  <= cfg_par_sel;
      pstk_q  <= cfg_par_stick;
    end
  end

  always_comb begin
    in_ready = (state_q == ST_IDLE);
    busy     = !in_ready;
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = data_q[idx_q];
      ST_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
    if (state_q == ST_STOP && stopl_q) limit = (len_q == 2'd0) ? LIM_HALF : LIM_TWO;
    else limit = LIM_BIT;
    frame_data      = data_q;
    frame_len       = len_q;
    frame_par_sel   = psel_q;
    frame_par_stick = pstk_q;
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_stop_long,
  input  logic              cfg_par_en,
  input  logic              cfg_par_sel,
  input  logic              cfg_par_stick,
  input  logic              cfg_break,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd
);

  localparam int CNT_W = $clog2(2 * OSR + 1);

  logic              rst_s1_q, rst_s2_q;
  logic              busy, phase_end, par_bit, line;
  logic [CNT_W-1:0]  limit;
  logic [DATA_W-1:0] frame_data;
  logic [1:0]        frame_len;
  logic              frame_par_sel, frame_par_stick;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  uart_tx_seq #(.DATA_W(DATA_W), .OSR(OSR), .CNT_W(CNT_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_s2_q),
    .phase_end       (phase_end),
    .par_bit         (par_bit),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .cfg_len         (cfg_len),
    .cfg_stop_long   (cfg_stop_long),
    .cfg_par_en      (cfg_par_en),
    .cfg_par_sel     (cfg_par_sel),
    .cfg_par_stick   (cfg_par_stick),
    .in_ready        (in_ready),
    .busy            (busy),
    .line            (line),
    .limit           (limit),
    .frame_data      (frame_data),
    .frame_len       (frame_len),
    .frame_par_sel   (frame_par_sel),
    .frame_par_stick (frame_par_stick)
  );

  uart_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .busy      (busy),
    .tick      (tick16),
    .limit     (limit),
    .phase_end (phase_end)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (frame_data),
    .len     (frame_len),
    .sel     (frame_par_sel),
    .stick   (frame_par_stick),
    .par_bit (par_bit)
  );

  assign txd = line && !cfg_break;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick16,
  input logic [1:0]        cfg_len,
  input logic              cfg_stop_long,
  input logic              cfg_par_en,
  input logic              cfg_par_sel,
  input logic              cfg_par_stick,
  input logic              cfg_break,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              txd
);

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !cfg_break) |-> txd);

  // R2
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !txd);

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !txd);

  // R12
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !tick16) |=> !in_ready);

  // R12
  hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !tick16 && !cfg_break) |=> ($stable(txd) || cfg_break));

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DATA_W(DATA_W), .OSR(OSR)) u_chk (.*);

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, tick16, tick_en;
  logic [1:0] cfg_len;
  logic       cfg_stop_long, cfg_par_en, cfg_par_sel, cfg_par_stick, cfg_break;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready, txd;

  int    tests, fails, tdiv;
  string cur_req;
  bit    q[$];

  uart_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_len(cfg_len),
    .cfg_stop_long(cfg_stop_long), .cfg_par_en(cfg_par_en),
    .cfg_par_sel(cfg_par_sel), .cfg_par_stick(cfg_par_stick),
    .cfg_break(cfg_break), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // tick every third clock when enabled
  always @(negedge clk) begin
    tdiv   <= (tdiv == 2) ? 0 : tdiv + 1;
    tick16 <= tick_en && (tdiv == 2);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: one queue entry per tick of line level
  task automatic build_frame();
    int  nb, ones, nstop;
    bit  par;
    nb   = 5 + int'(cfg_len);
    ones = 0;
    repeat (16) q.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      ones += int'(in_data[i]);
      repeat (16) q.push_back(in_data[i]);
    end
    if (cfg_par_en) begin
      if (cfg_par_stick) par = !cfg_par_sel;
      else if (cfg_par_sel) par = (ones % 2) == 1;
      else par = (ones % 2) == 0;
      repeat (16) q.push_back(par);
    end
    nstop = !cfg_stop_long ? 16 : (cfg_len == 2'd0 ? 24 : 32);
    repeat (nstop) q.push_back(1'b1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) q.delete();
    else if (q.size() == 0) begin
      if (in_valid) build_frame();
    end else if (tick16) void'(q.pop_front());
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit et, er;
      et = cfg_break ? 1'b0 : (q.size() != 0 ? q[0] : 1'b1);
      er = (q.size() == 0);
      check(txd == et, {cur_req, " txd"}, int'(txd), int'(et));
      check(in_ready == er, {cur_req, " in_ready"}, int'(in_ready), int'(er));
    end
  end

  task automatic set_cfg(input logic [1:0] len, input bit sl, input bit pe,
                         input bit ps, input bit pk);
    cfg_len = len; cfg_stop_long = sl; cfg_par_en = pe;
    cfg_par_sel = ps; cfg_par_stick = pk;
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] d, input string req);
    int f0;
    cur_req = req;
    f0 = fails;
    offer(d);
    wait_idle();
    repeat (3) @(negedge clk);
    check(fails == f0, {req, " frame matches reference"}, fails - f0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int   f0;
    logic t0;
    tests = 0; fails = 0; tdiv = 0; cur_req = "R1";
    rst_n = 1'b0; tick_en = 1'b1; tick16 = 1'b0;
    in_valid = 1'b0; in_data = '0; cfg_break = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
    check(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);

    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    frame(8'hA5, "R3 8 bits lsb first");
    frame(8'h3C, "R5 one stop");
    frame(8'h81, "R7 no parity");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    frame(8'hF3, "R4 five bits");
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    frame(8'hEA, "R4 six bits");
    set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    frame(8'h13, "R6 one and a half stop");
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    frame(8'h2D, "R6 two stop six bits");
    set_cfg(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);
    frame(8'hFF, "R6 two stop eight bits");
    set_cfg(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    frame(8'h55, "R8 odd parity");
    set_cfg(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    frame(8'h37, "R8 even parity");
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    frame(8'hE0, "R8 odd parity zero data");
    set_cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    frame(8'h00, "R9 stick one");
    set_cfg(2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    frame(8'hFF, "R9 stick zero");

    // R10: break in the middle of a frame
    cur_req = "R10"; f0 = fails;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    offer(8'hFF);
    repeat (100) @(negedge clk);
    cfg_break = 1'b1;
    #2;
    check(txd == 1'b0, "R10 break immediate", int'(txd), 0);
    repeat (60) @(negedge clk);
    cfg_break = 1'b0;
    wait_idle();
    check(fails == f0, "R10 frame continues under break", fails - f0, 0);

    // R11: configuration changes after accept
    cur_req = "R11"; f0 = fails;
    set_cfg(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    offer(8'h96);
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    wait_idle();
    check(fails == f0, "R11 settings held for frame", fails - f0, 0);

    // R12: ticks paused mid-frame
    cur_req = "R12"; f0 = fails;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    offer(8'h5A);
    repeat (90) @(negedge clk);
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    t0 = txd;
    repeat (50) @(negedge clk);
    #2;
    check(txd == t0, "R12 line held without ticks", int'(txd), int'(t0));
    check(in_ready == 1'b0, "R12 still busy", int'(in_ready), 0);
    tick_en = 1'b1;
    wait_idle();
    check(fails == f0, "R12 frame resumes", fails - f0, 0);

    // R2: back-to-back offers with valid held high
    cur_req = "R2"; f0 = fails;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    in_data = 8'h4B;
    #2;
    check(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
    wait_idle();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();
    check(fails == f0, "R2 back-to-back frames", fails - f0, 0);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule